// File: doc/BRIEF.md
# DMA Bus Handover Controller

This controller arbitrates a single I/O device's claim on the shared system bus against the processor that normally owns it. When the device raises its request, the controller asks the processor to halt. It waits for the processor to report that the bus is free. Only then does it grant the device and enable the memory, so that the device can move data directly. Address, data and the read/write strobe are driven by the device and the processor outside this block.

The sequencing is done by a four-state machine:
- `HS_IDLE`: the bus belongs to the processor.
- `HS_WAIT`: halt is requested and the controller waits for bus-free.
- `HS_GRANT`: acknowledge and memory enable are active.
- `HS_RELEASE`: halt is withdrawn and the controller waits for the processor to take the bus back.

The transitions are:
- IDLE→WAIT on an armed request.
- WAIT→GRANT on bus-free.
- WAIT→IDLE when the wait limit expires.
- GRANT→RELEASE on end-of-transfer.
- RELEASE→IDLE when bus-free drops.

All outputs come straight from flops. A flag records that the processor once failed to answer in time, and it stays set until reset.

Top module: `dma_handover_ctrl`

## Requirements
- R1: In idle, a sampled `dev_req` high that is armed moves the block to the waiting state on that edge: `cpu_hold_n` goes low (halt is active low) and `busy` goes high.
- R2: While waiting, `dev_ack` stays low and `mem_sel_n` stays high as long as `cpu_bus_free` is sampled low.
- R3: On the edge that samples `cpu_bus_free` high while waiting, the block moves to the granted state. On that same edge `dev_ack` goes high and `mem_sel_n` goes low (active low), while `cpu_hold_n` stays low.
- R4: On the edge that samples `dev_done_n` low while granted, `dev_ack` falls, `mem_sel_n` rises and `cpu_hold_n` rises, all together.
- R5: After release, `busy` stays high until `cpu_bus_free` is sampled low. On that edge the block returns to idle.
- R6: A request is armed at reset. It is disarmed on each grant, and re-armed only once `dev_req` has been sampled low. A request held high through a whole transfer therefore does not start a second one.
- R7: An asynchronous low `rst_n` immediately forces idle: `cpu_hold_n`=1, `dev_ack`=0, `mem_sel_n`=1, `busy`=0, `wait_expired`=0.
- R8: `busy` is high in every state except idle.
- R9: If `cpu_bus_free` is not sampled high on any of the `WAIT_LIMIT` edges after entering the waiting state, then on the last of those edges the block does three things: it raises `cpu_hold_n`, it returns to idle, and it sets `wait_expired`, which stays high until reset.
- R10: `cpu_bus_free` sampled high on the final (`WAIT_LIMIT`-th) waiting edge grants the device rather than timing out.
- R11: `dev_req` has no effect on the outputs while the block is waiting, granted or releasing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| dev_req | input | 1 | Transfer request from the I/O device |
| dev_done_n | input | 1 | End of transfer from the device, active low |
| dev_ack | output | 1 | Grant to the device, active high |
| cpu_bus_free | input | 1 | Processor reports the bus is released |
| cpu_hold_n | output | 1 | Halt request to the processor, active low |
| mem_sel_n | output | 1 | Memory chip enable, active low |
| busy | output | 1 | High whenever not idle |
| wait_expired | output | 1 | Sticky flag: the processor did not free the bus in time |

## Verification
The hardest situation to reach is the boundary between grant and timeout, where `cpu_bus_free` arrives on exactly the last permitted waiting edge. The bench reaches it by reducing `WAIT_LIMIT` to 4 and counting waiting edges precisely before raising bus-free. It then repeats the same count with bus-free withheld to force the timeout. The re-arm rule is also reached on purpose: a request is held high straight through a transfer, and the bench shows that idle persists until the request drops.

// File: rtl/dma_hs_pkg.sv
package dma_hs_pkg;

    typedef enum logic [1:0] {
        HS_IDLE    = 2'd0,
        HS_WAIT    = 2'd1,
        HS_GRANT   = 2'd2,
        HS_RELEASE = 2'd3
    } hs_state_e;

    typedef struct packed {
        logic hold_n;
        logic ack;
        logic sel_n;
        logic busy;
    } hs_outs_t;

    function automatic hs_outs_t hs_decode(hs_state_e s);
        hs_outs_t o;
        o = '{hold_n: 1'b1, ack: 1'b0, sel_n: 1'b1, busy: 1'b0};
        unique case (s)
            HS_IDLE:    o = '{hold_n: 1'b1, ack: 1'b0, sel_n: 1'b1, busy: 1'b0};
            HS_WAIT:    o = '{hold_n: 1'b0, ack: 1'b0, sel_n: 1'b1, busy: 1'b1};
            HS_GRANT:   o = '{hold_n: 1'b0, ack: 1'b1, sel_n: 1'b0, busy: 1'b1};
            HS_RELEASE: o = '{hold_n: 1'b1, ack: 1'b0, sel_n: 1'b1, busy: 1'b1};
            default:    o = '{hold_n: 1'b1, ack: 1'b0, sel_n: 1'b1, busy: 1'b0};
        endcase
        return o;
    endfunction

endpackage

// File: rtl/dma_hs_timer.sv
module dma_hs_timer #(
    parameter int LIMIT = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    output logic expired
);
    localparam int CW = (LIMIT > 2) ? $clog2(LIMIT) : 1;
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (!active)
            cnt_q <= '0;
        else if (cnt_q != LAST)
            cnt_q <= cnt_q + 1'b1;
    end

    assign expired = active && (cnt_q == LAST);

    AST_CNT_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);  // R9
endmodule

// File: rtl/dma_hs_rearm.sv
module dma_hs_rearm (
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    input  logic grant_evt,
    output logic armed
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            armed <= 1'b1;
        else if (grant_evt)
            armed <= 1'b0;
        else if (!req)
            armed <= 1'b1;
    end

    AST_DISARM_ON_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        grant_evt |=> !armed);  // R6
endmodule

// File: rtl/dma_handover_ctrl.sv
module dma_handover_ctrl
    import dma_hs_pkg::*;
#(
    parameter int WAIT_LIMIT = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic dev_req,
    input  logic dev_done_n,
    output logic dev_ack,
    input  logic cpu_bus_free,
    output logic cpu_hold_n,
    output logic mem_sel_n,
    output logic busy,
    output logic wait_expired
);
    hs_state_e st_q, st_d;
    hs_outs_t  outs_d;
    logic      expired;
    logic      armed;
    logic      grant_evt;
    logic      timeout_evt;

    dma_hs_timer #(.LIMIT(WAIT_LIMIT)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .active  (st_q == HS_WAIT),
        .expired (expired)
    );

    dma_hs_rearm u_rearm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (dev_req),
        .grant_evt (grant_evt),
        .armed     (armed)
    );

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            HS_IDLE:    if (dev_req && armed)   st_d = HS_WAIT;
            HS_WAIT:    if (cpu_bus_free)       st_d = HS_GRANT;
                        else if (expired)       st_d = HS_IDLE;
            HS_GRANT:   if (!dev_done_n)        st_d = HS_RELEASE;
            HS_RELEASE: if (!cpu_bus_free)      st_d = HS_IDLE;
            default:                            st_d = HS_IDLE;
        endcase
    end

    assign grant_evt   = (st_q == HS_WAIT) && (st_d == HS_GRANT);
    assign timeout_evt = (st_q == HS_WAIT) && (st_d == HS_IDLE);
    assign outs_d      = hs_decode(st_d);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= HS_IDLE;
        else
            st_q <= st_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cpu_hold_n   <= 1'b1;
            dev_ack      <= 1'b0;
            mem_sel_n    <= 1'b1;
            busy         <= 1'b0;
            wait_expired <= 1'b0;
        end else begin
            cpu_hold_n   <= outs_d.hold_n;
            dev_ack      <= outs_d.ack;
            mem_sel_n    <= outs_d.sel_n;
            busy         <= outs_d.busy;
            if (timeout_evt)
                wait_expired <= 1'b1;
        end
    end

    AST_GRANT_NEEDS_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dev_ack) |-> $past(cpu_bus_free));  // R3
    AST_GRANT_UNDER_HALT: assert property (@(posedge clk) disable iff (!rst_n)
        dev_ack |-> (!cpu_hold_n && !mem_sel_n));  // R3
    AST_DONE_DROPS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_ack && !dev_done_n) |=> (!dev_ack && mem_sel_n && cpu_hold_n));  // R4
    AST_RELEASE_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cpu_hold_n && cpu_bus_free) |=> busy);  // R5
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (cpu_hold_n && !dev_ack && mem_sel_n));  // R8
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        wait_expired |=> wait_expired);  // R9
endmodule

// File: tb/tb_dma_handover_ctrl.sv
`timescale 1ns/1ps
module tb_dma_handover_ctrl;
    localparam int LIM = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic dev_req = 1'b0, dev_done_n = 1'b1, cpu_bus_free = 1'b0;
    logic dev_ack, cpu_hold_n, mem_sel_n, busy, wait_expired;

    int checks = 0;
    int errors = 0;

    logic [4:0] expq[$];
    string      tagq[$];

    // {hold_n, ack, sel_n, busy, flag}
    localparam logic [4:0] V_IDLE = 5'b10100;
    localparam logic [4:0] V_WAIT = 5'b00110;
    localparam logic [4:0] V_GRNT = 5'b01010;
    localparam logic [4:0] V_REL  = 5'b10110;

    always #2.5 clk = ~clk;

    dma_handover_ctrl #(.WAIT_LIMIT(LIM)) dut (
        .clk(clk), .rst_n(rst_n), .dev_req(dev_req), .dev_done_n(dev_done_n),
        .dev_ack(dev_ack), .cpu_bus_free(cpu_bus_free), .cpu_hold_n(cpu_hold_n),
        .mem_sel_n(mem_sel_n), .busy(busy), .wait_expired(wait_expired)
    );

    function automatic logic [4:0] outs();
        return {cpu_hold_n, dev_ack, mem_sel_n, busy, wait_expired};
    endfunction

    task automatic compare(logic [4:0] exp, string tag);
        checks++;
        if (outs() !== exp) begin
            errors++;
            $display("FAIL %s: got %b expected %b", tag, outs(), exp);
        end
    endtask

    // driver: apply inputs, queue expected outputs after the next edge
    task automatic step(logic req, logic free, logic done_n, logic [4:0] exp, string tag);
        @(negedge clk);
        dev_req = req; cpu_bus_free = free; dev_done_n = done_n;
        expq.push_back(exp);
        tagq.push_back(tag);
    endtask

    // monitor: compare just after each edge
    always @(posedge clk) begin
        #1;
        if (expq.size() > 0) compare(expq.pop_front(), tagq.pop_front());
    end

    initial begin
        #100000;
        checks++; errors++;
        $display("FAIL watchdog: got hung expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #12;
        compare(V_IDLE, "R7 reset state");
        rst_n = 1'b1;
        step(0,0,1, V_IDLE, "R8 idle not busy");
        step(1,0,1, V_WAIT, "R1 request halts cpu");
        step(1,0,1, V_WAIT, "R2 no grant before bus free");
        step(1,1,1, V_GRNT, "R3 grant with chip enable");
        step(0,1,1, V_GRNT, "R11 request drop ignored in grant");
        step(1,1,1, V_GRNT, "R11 request ignored in grant");
        step(1,1,0, V_REL,  "R4 end of transfer");
        step(1,1,1, V_REL,  "R5 waits for bus free low");
        step(1,0,1, V_IDLE, "R5 back to idle");
        // request held high through whole transfer
        step(1,0,1, V_WAIT, "R1 armed request");
        step(1,1,1, V_GRNT, "R3 second grant");
        step(1,1,0, V_REL,  "R4 second end");
        step(1,0,1, V_IDLE, "R5 second idle");
        step(1,0,1, V_IDLE, "R6 not rearmed");
        step(1,0,1, V_IDLE, "R6 still not rearmed");
        step(0,0,1, V_IDLE, "R6 request drops");
        step(1,0,1, V_WAIT, "R6 rearmed request");
        // bus free on final permitted wait edge
        step(1,0,1, V_WAIT, "R10 wait 1");
        step(1,0,1, V_WAIT, "R10 wait 2");
        step(1,0,1, V_WAIT, "R10 wait 3");
        step(1,1,1, V_GRNT, "R10 grant on last edge");
        step(0,1,0, V_REL,  "R4 end after late grant");
        step(0,0,1, V_IDLE, "R5 idle after late grant");
        // timeout
        step(1,0,1, V_WAIT, "R1 request before timeout");
        step(0,0,1, V_WAIT, "R9 wait 1");
        step(0,0,1, V_WAIT, "R9 wait 2");
        step(0,0,1, V_WAIT, "R9 wait 3");
        step(0,0,1, V_IDLE | 5'b00001, "R9 timeout releases halt");
        step(0,0,1, V_IDLE | 5'b00001, "R9 flag sticky");
        step(1,0,1, V_WAIT | 5'b00001, "R9 flag kept while waiting");
        step(1,1,1, V_GRNT | 5'b00001, "R3 grant after timeout");
        step(1,1,0, V_REL  | 5'b00001, "R4 end with flag");
        step(0,0,1, V_IDLE | 5'b00001, "R9 flag kept in idle");
        step(1,0,1, V_WAIT | 5'b00001, "R1 request before reset");
        step(1,1,1, V_GRNT | 5'b00001, "R3 grant before reset");
        wait (expq.size() == 0);
        @(negedge clk);
        rst_n = 1'b0; dev_req = 1'b0;
        #1;
        compare(V_IDLE, "R7 async reset mid grant");
        @(negedge clk);
        rst_n = 1'b1;
        step(0,1,1, V_IDLE, "R7 idle after reset");
        wait (expq.size() == 0);
        @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule